// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

This block turns a serial stream of message bits into a serial stream of coded bits using a rate one-half convolutional code with constraint length three. A small history register remembers the two message bits that came before the current one. Two parity equations over the current bit and that history give a pair of coded bits for every message bit. The pair leaves on one serial output, first parity first.

Both ends use a valid/ready handshake. The producer offers one message bit at a time. The consumer may stall the output for as long as it likes, and the encoder holds its coded bit until the consumer takes it. A flush request closes a frame: it injects zero message bits until the history is all zero again, so a decoder can end its trellis in the zero state. A new message bit can be taken in the same cycle that the last coded bit of the previous one is taken, so the stream runs at one coded bit per cycle when nothing stalls.

Top module: `conv_half_enc`

## Requirements
- R1: A synchronous reset, active high, clears the history to zero, drops out_valid and raises in_ready. The first message bit after reset is therefore encoded against an all-zero history.
- R2: The first coded bit sent for a message bit is the current bit XOR the bit two places back (generator 101).
- R3: The second coded bit sent for a message bit is the XOR of the current bit and both previous bits (generator 111).
- R4: in_ready is high when no coded bit is pending. It is also high in a cycle where the second coded bit of the last pending message bit is taken. In every other cycle it is low, and in particular it is low whenever out_valid is high and out_ready is low.
- R5: After both coded bits of a message bit are taken, the history shifts: the bit one place back moves two places back, and the current bit becomes the bit one place back.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_bit keeps its value in the next cycle.
- R7: A flush_req taken while in_ready is high injects two zero message bits. This sends four coded bits and leaves the history at zero. in_ready stays low until the last of those bits is taken. When flush_req and in_valid are both high, the flush wins and in_bit is discarded.
- R8: A message bit is taken only in a cycle where in_valid and in_ready are both high. An in_bit offered while in_ready is low has no effect on the coded stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A message bit is offered |
| in_bit | input | 1 | Message bit |
| flush_req | input | 1 | Request to terminate the frame with zero tail bits |
| in_ready | output | 1 | Encoder can take a message bit or a flush request |
| out_valid | output | 1 | A coded bit is presented |
| out_bit | output | 1 | Coded bit |
| out_ready | input | 1 | Consumer takes the coded bit |

## Verification
The bench encodes every 8-bit message pattern and closes each one with a flush. This exposes swapped generators, a wrong parity order, a history that shifts on the first coded bit instead of the second, and a tail that leaves stale history behind. Each of these shows up as wrong coded bits in the next frame. An irregular backpressure pattern tests whether out_bit stays put under a stall, and whether in_ready drops while a bit is blocked. A design that got the stall wrong would skip or duplicate coded bits. During stalls the bench offers an inverted message bit, to catch a design that samples in_bit without in_ready. Flush requests arrive together with a valid bit to check that the flush takes priority. A final run without backpressure checks that the block takes a new bit in the same cycle as the last coded bit of the previous one.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

    // Default code: constraint length 3, generators over {S2,S1,S0}
    localparam int unsigned CL_DEFAULT = 3;
    localparam logic [CL_DEFAULT-1:0] GEN_A_DEFAULT = 3'b101;
    localparam logic [CL_DEFAULT-1:0] GEN_B_DEFAULT = 3'b111;

    // Which coded bit of the pair is on the output
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } enc_phase_e;

    // What the sequencer loads into the current-bit stage
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_DATA = 2'd1,
        LD_ZERO = 2'd2
    } enc_load_e;

    // Odd parity over a tapped window, widened to a fixed width
    function automatic logic tap_parity(input logic [15:0] window, input logic [15:0] taps);
        return ^(window & taps);
    endfunction

endpackage

// File: rtl/conv_enc_shreg.sv
module conv_enc_shreg
    import conv_enc_pkg::*;
#(
    parameter int unsigned CL = CL_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  enc_load_e     load_sel,
    input  logic          load_bit,
    input  logic          shift_en,
    output logic [CL-1:0] window
);
    localparam int unsigned MEM = CL - 1;

    logic           cur_q;
    logic [MEM-1:0] hist_q; // hist_q[0] is one place back

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= 1'b0;
            hist_q <= '0;
        end else begin
            if (shift_en) begin
                if (MEM > 1) begin
                    hist_q <= {hist_q[MEM-2:0], cur_q};
                end else begin
                    hist_q <= MEM'(cur_q);
                end
            end
            unique case (load_sel)
                LD_DATA: cur_q <= load_bit;
                LD_ZERO: cur_q <= 1'b0;
                default: cur_q <= cur_q;
            endcase
        end
    end

    assign window = {hist_q, cur_q};

endmodule

// File: rtl/conv_enc_seq.sv
module conv_enc_seq
    import conv_enc_pkg::*;
#(
    parameter int unsigned CL = CL_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       flush_req,
    input  logic       out_ready,
    output logic       in_ready,
    output logic       busy,
    output enc_phase_e phase,
    output enc_load_e  load_sel,
    output logic       shift_en
);
    localparam int unsigned TAIL   = CL - 1;
    localparam int unsigned TAIL_W = $clog2(TAIL + 1);

    logic              busy_q;
    enc_phase_e        phase_q;
    logic [TAIL_W-1:0] tail_q;

    logic out_fire;
    logic pair_done;
    logic tail_more;
    logic take_flush;
    logic take_data;

    always_comb begin
        out_fire   = busy_q && out_ready;
        pair_done  = out_fire && (phase_q == PH_SECOND);
        tail_more  = (tail_q != '0);
        in_ready   = !busy_q || (pair_done && !tail_more);
        take_flush = in_ready && flush_req;
        take_data  = in_ready && in_valid && !flush_req;
        shift_en   = pair_done;
        if (pair_done && tail_more) begin
            load_sel = LD_ZERO;
        end else if (take_flush) begin
            load_sel = LD_ZERO;
        end else if (take_data) begin
            load_sel = LD_DATA;
        end else begin
            load_sel = LD_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= PH_FIRST;
            tail_q  <= '0;
        end else if (pair_done && tail_more) begin
            busy_q  <= 1'b1;
            phase_q <= PH_FIRST;
            tail_q  <= tail_q - 1'b1;
        end else if (take_flush) begin
            busy_q  <= 1'b1;
            phase_q <= PH_FIRST;
            tail_q  <= TAIL_W'(TAIL - 1);
        end else if (take_data) begin
            busy_q  <= 1'b1;
            phase_q <= PH_FIRST;
        end else if (pair_done) begin
            busy_q  <= 1'b0;
            phase_q <= PH_FIRST;
        end else if (out_fire) begin
            phase_q <= PH_SECOND;
        end
    end

    assign busy  = busy_q;
    assign phase = phase_q;

endmodule

// File: rtl/conv_enc_parity.sv
module conv_enc_parity
    import conv_enc_pkg::*;
#(
    parameter int unsigned    CL    = CL_DEFAULT,
    parameter logic [CL-1:0]  GEN_A = GEN_A_DEFAULT,
    parameter logic [CL-1:0]  GEN_B = GEN_B_DEFAULT
) (
    input  logic [CL-1:0] window,
    input  enc_phase_e    phase,
    output logic          coded
);
    localparam int unsigned NGEN = 2;

    logic [NGEN-1:0] par;
    logic [NGEN-1:0][CL-1:0] gens;

    assign gens[0] = GEN_A;
    assign gens[1] = GEN_B;

    for (genvar g = 0; g < NGEN; g++) begin : g_par
        assign par[g] = tap_parity(16'(window), 16'(gens[g]));
    end

    assign coded = (phase == PH_SECOND) ? par[1] : par[0];

endmodule

// File: rtl/conv_half_enc.sv
module conv_half_enc
    import conv_enc_pkg::*;
#(
    parameter int unsigned   CL    = CL_DEFAULT,
    parameter logic [CL-1:0] GEN_A = GEN_A_DEFAULT,
    parameter logic [CL-1:0] GEN_B = GEN_B_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic flush_req,
    output logic in_ready,
    output logic out_valid,
    output logic out_bit,
    input  logic out_ready
);
    logic          busy;
    enc_phase_e    phase;
    enc_load_e     load_sel;
    logic          shift_en;
    logic [CL-1:0] window;

    conv_enc_seq #(.CL(CL)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .flush_req (flush_req),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .busy      (busy),
        .phase     (phase),
        .load_sel  (load_sel),
        .shift_en  (shift_en)
    );

    conv_enc_shreg #(.CL(CL)) i_shreg (
        .clk      (clk),
        .rst      (rst),
        .load_sel (load_sel),
        .load_bit (in_bit),
        .shift_en (shift_en),
        .window   (window)
    );

    conv_enc_parity #(.CL(CL), .GEN_A(GEN_A), .GEN_B(GEN_B)) i_par (
        .window (window),
        .phase  (phase),
        .coded  (out_bit)
    );

    assign out_valid = busy;

endmodule

// File: rtl/conv_half_enc_chk.sv
module conv_half_enc_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_bit,
    input logic flush_req,
    input logic in_ready,
    input logic out_valid,
    input logic out_bit,
    input logic out_ready
);
    AST_RST_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && in_ready)); // R1

    AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid); // R8

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R4

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R6

    AST_FLUSH_EMITS: assert property (@(posedge clk) disable iff (rst)
        (flush_req && in_ready) |=> out_valid); // R7

    logic unused_in_bit;
    assign unused_in_bit = in_bit;

endmodule

bind conv_half_enc conv_half_enc_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .flush_req (flush_req),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_ready (out_ready)
);

// File: tb/test_conv_half_enc.sv
`timescale 1ns/100ps
module test_conv_half_enc;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic flush_req = 1'b0;
    logic in_ready;
    logic out_valid;
    logic out_bit;
    logic out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    conv_half_enc i_conv_half_enc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .flush_req (flush_req),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_ready (out_ready)
    );

    // reference model: expected coded bits and their kind (1 first, 2 second, 3 tail)
    logic exp_q[$];
    int   tag_q[$];
    logic m_s1 = 1'b0;
    logic m_s2 = 1'b0;
    logic hold_pend = 1'b0;
    logic hold_bit = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_push(input logic b, input int kind);
        logic v1, v2;
        v1 = b ^ m_s2;
        v2 = b ^ m_s1 ^ m_s2;
        exp_q.push_back(v1); tag_q.push_back(kind == 3 ? 3 : 1);
        exp_q.push_back(v2); tag_q.push_back(kind == 3 ? 3 : 2);
        m_s2 = m_s1;
        m_s1 = b;
    endtask

    function automatic logic pred_ready(input logic ordy);
        return (exp_q.size() == 0) || (exp_q.size() == 1 && ordy);
    endfunction

    task automatic next_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // one cycle: drive after the falling edge, sample, then advance the model
    task automatic step(input logic iv, input logic ib, input logic fl, input logic ordy,
                        output logic took);
        logic e_ov, e_ir;
        @(negedge clk);
        in_valid = iv; in_bit = ib; flush_req = fl; out_ready = ordy;
        #1;
        e_ov = (exp_q.size() != 0);
        e_ir = pred_ready(ordy);
        check(out_valid == e_ov, "R4 out_valid", int'(out_valid), int'(e_ov));
        check(in_ready == e_ir, "R4 in_ready", int'(in_ready), int'(e_ir));
        if (out_valid && !ordy)
            check(!in_ready, "R4 stall", int'(in_ready), 0);
        if (hold_pend)
            check(out_valid && out_bit == hold_bit, "R6 hold", int'(out_bit), int'(hold_bit));
        if (e_ov && out_valid) begin
            case (tag_q[0])
                1: check(out_bit == exp_q[0], "R2 first", int'(out_bit), int'(exp_q[0]));
                2: check(out_bit == exp_q[0], "R3 R5 second", int'(out_bit), int'(exp_q[0]));
                default: check(out_bit == exp_q[0], "R7 tail", int'(out_bit), int'(exp_q[0]));
            endcase
        end
        hold_pend = out_valid && !ordy;
        hold_bit  = out_bit;
        if (e_ov && ordy) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        took = 1'b0;
        if (e_ir && fl) begin
            model_push(1'b0, 3);
            model_push(1'b0, 3);
            took = 1'b1;
        end else if (e_ir && iv) begin
            model_push(ib, 0);
            took = 1'b1;
        end
    endtask

    task automatic send_bit(input logic b, input bit bp);
        logic took, ordy;
        took = 1'b0;
        while (!took) begin
            next_lfsr();
            ordy = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
            if (bp && lfsr[5] && lfsr[7]) begin
                step(1'b0, ~b, 1'b0, ordy, took); // gap, in_bit is junk
            end else if (!pred_ready(ordy)) begin
                step(1'b1, ~b, 1'b0, ordy, took); // R8: not ready, wrong bit offered
                check(!took, "R8 ignored", int'(took), 0);
            end else begin
                step(1'b1, b, 1'b0, ordy, took);
            end
        end
    endtask

    task automatic send_flush(input logic with_data);
        logic took, ordy;
        took = 1'b0;
        while (!took) begin
            next_lfsr();
            ordy = lfsr[1] | lfsr[4];
            step(with_data, lfsr[2], 1'b1, ordy, took); // R7 flush wins over data
        end
    endtask

    task automatic drain();
        logic took;
        while (exp_q.size() != 0) begin
            next_lfsr();
            step(1'b0, 1'b0, 1'b0, lfsr[0] | lfsr[6], took);
        end
    endtask

    initial begin
        logic took;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid, "R1 out_valid", int'(out_valid), 0);
        check(in_ready, "R1 in_ready", int'(in_ready), 1);
        // R1: first bit 1 after reset encodes to 1,1 against zero history
        send_bit(1'b1, 1'b0);
        drain();
        send_flush(1'b0);
        drain();
        // exhaustive 8-bit message patterns under backpressure, each closed by a flush
        for (int p = 0; p < 256; p++) begin
            for (int i = 7; i >= 0; i--) send_bit(p[i], 1'b1);
            send_flush(p[0]);
            if (p[1]) drain();
        end
        drain();
        // R4: back-to-back stream at full rate
        for (int i = 0; i < 64; i++) begin
            next_lfsr();
            send_bit(lfsr[9], 1'b0);
        end
        send_flush(1'b0);
        drain();
        step(1'b0, 1'b0, 1'b0, 1'b1, took);
        check(m_s1 == 1'b0 && m_s2 == 1'b0, "R7 model zero", int'({m_s2, m_s1}), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule